// File: doc/BRIEF.md
# Power Management Event Enable Router

This block holds the 16-bit enable register of a power management event block and turns each enable bit, together with its matching event status input, into three outputs: a system control interrupt (SCI), a system management interrupt (SMI) and a wake request. Software reaches the register through a simple read/write port. The register sits at offset 02h of the power management I/O window. The status latches, the address decoder and the power sequencer live outside the block and drive its inputs.

The writable bits fall into three power domains, and each domain has its own asynchronous reset:

- The core reset clears the timer overflow enable and the global enable.
- The resume reset clears the power button enable and the PCIe wake disable.
- The RTC event enable is cleared only by the RTC reset or by a power button override pulse. It therefore survives every other reset.

The timer, power button and RTC events are steered by a mode input. They raise an SCI when the mode is 1 and an SMI when it is 0. The global event always raises an SCI. The PCIe wake source uses a disable bit, so it wakes the system when that bit is 0.

Top module: `pm_event_enable`

## Requirements
- R1: After all three resets the register reads 0000h. A read at offset 02h returns the register, and a read at any other offset returns 0000h.
- R2: A write at offset 02h changes the register in the cycle after it is accepted. Only bits 0, 5, 8, 10 and 14 are stored (mask 4521h). All other bits read as 0 and ignore writes. A write at any other offset leaves the register unchanged.
- R3: The core reset clears bits 0 and 5 and leaves bits 8, 10 and 14 unchanged.
- R4: The resume reset clears bits 8 and 14 and leaves bits 0, 5 and 10 unchanged.
- R5: Bit 10 is cleared only by the RTC reset or by a power button override pulse at a clock edge. The override wins over a write in the same cycle. No other input changes bit 10 except a write.
- R6: When the timer status is 1 and bit 0 is 1, the block raises SMI if the mode input is 0 and SCI if it is 1. When bit 0 is 0, the timer raises no interrupt.
- R7: When bit 5 and the global status are both 1, SCI is 1, whatever the mode input.
- R8: Bit 8 gates only the interrupt from the power button status, which is steered like the timer. The power button status drives the wake output whatever the value of bit 8.
- R9: When bit 10 and the RTC status are both 1, the block raises a steered interrupt and a wake request. When bit 10 is 0, the RTC status causes neither.
- R10: The PCIe wake status drives the wake output only while bit 14 is 0. It never raises an interrupt.
- R11: SCI, SMI and wake are levels formed in the same cycle from the stored bits and the present status inputs. They are held for as long as an enabled status input stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| core_rst_n | input | 1 | Core domain reset, async, active low |
| resume_rst_n | input | 1 | Resume domain reset, async, active low |
| rtc_rst_n | input | 1 | RTC domain reset, async, active low |
| pwrbtn_ovr | input | 1 | Power button override pulse, clears bit 10 |
| addr | input | ADDR_W | Register offset within the power management window |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| tmr_sts | input | 1 | Timer overflow status |
| gbl_sts | input | 1 | Global status |
| pwrbtn_sts | input | 1 | Power button status |
| rtc_sts | input | 1 | RTC event status |
| pcie_wake_sts | input | 1 | PCIe wake status |
| sci_mode | input | 1 | Steering mode: 1 selects SCI, 0 selects SMI |
| sci | output | 1 | SCI level |
| smi | output | 1 | SMI level |
| wake | output | 1 | Wake request level |

## Verification
Status inputs reach SCI, SMI and wake with no register in the path. A write or an override pulse moves rdata and the outputs one clock edge after it is presented. A reset moves them as soon as it is asserted. The bench drives every input just after a falling edge. It updates its behavioural model right after the next rising edge and compares all outputs at the following falling edge. Every expectation therefore already includes the single register stage, and combinational paths are settled by the time they are sampled.

// File: rtl/pm_event_enable.sv
module pm_event_enable #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h02
) (
  input  logic              clk,
  input  logic              core_rst_n,
  input  logic              resume_rst_n,
  input  logic              rtc_rst_n,
  input  logic              pwrbtn_ovr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic              tmr_sts,
  input  logic              gbl_sts,
  input  logic              pwrbtn_sts,
  input  logic              rtc_sts,
  input  logic              pcie_wake_sts,
  input  logic              sci_mode,
  output logic              sci,
  output logic              smi,
  output logic              wake
);
  localparam int B_TMR  = 0;
  localparam int B_GBL  = 5;
  localparam int B_PB   = 8;
  localparam int B_RTC  = 10;
  localparam int B_PCIE = 14;
  localparam logic [15:0] WMASK = 16'h4521;

  logic tmr_en, gbl_en, pb_en, rtc_en, pcie_dis;
  logic wr_hit;
  logic [15:0] regv;

  assign wr_hit = wr_en && (addr == REG_OFFSET);

  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n) begin
      tmr_en <= 1'b0;
      gbl_en <= 1'b0;
    end else if (wr_hit) begin
      tmr_en <= wdata[B_TMR];
      gbl_en <= wdata[B_GBL];
    end

  always_ff @(posedge clk or negedge resume_rst_n)
    if (!resume_rst_n) begin
      pb_en    <= 1'b0;
      pcie_dis <= 1'b0;
    end else if (wr_hit) begin
      pb_en    <= wdata[B_PB];
      pcie_dis <= wdata[B_PCIE];
    end

  always_ff @(posedge clk or negedge rtc_rst_n)
    if (!rtc_rst_n)      rtc_en <= 1'b0;
    else if (pwrbtn_ovr) rtc_en <= 1'b0;
    else if (wr_hit)     rtc_en <= wdata[B_RTC];

  always_comb begin
    regv         = '0;
    regv[B_TMR]  = tmr_en;
    regv[B_GBL]  = gbl_en;
    regv[B_PB]   = pb_en;
    regv[B_RTC]  = rtc_en;
    regv[B_PCIE] = pcie_dis;
  end

  assign rdata = (addr == REG_OFFSET) ? regv : 16'h0000;

  logic steer_hit;
  assign steer_hit = (tmr_en & tmr_sts) | (pb_en & pwrbtn_sts) | (rtc_en & rtc_sts);
  assign sci  = (steer_hit & sci_mode) | (gbl_en & gbl_sts);
  assign smi  = steer_hit & ~sci_mode;
  assign wake = (rtc_en & rtc_sts) | pwrbtn_sts | (pcie_wake_sts & ~pcie_dis);

  logic all_rst_n;
  assign all_rst_n = core_rst_n & resume_rst_n & rtc_rst_n;

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    (wr_hit && !pwrbtn_ovr) |=> (rdata == ((addr == REG_OFFSET) ? ($past(wdata) & WMASK) : 16'h0000)));

  // R5
  rtc_hold_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    (!wr_hit && !pwrbtn_ovr) |=> $stable(rtc_en));

  // R6
  smi_mode_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    smi |-> !sci_mode);

  // R7
  gbl_sci_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    (gbl_en && gbl_sts) |-> sci);

  // R8
  pb_wake_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    pwrbtn_sts |-> wake);

  // R10
  pcie_no_irq_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    (pcie_wake_sts && !tmr_sts && !gbl_sts && !pwrbtn_sts && !rtc_sts) |-> (!sci && !smi));
endmodule

// File: tb/pm_event_enable_test.sv
module pm_event_enable_test;
  logic clk = 0;
  always #5 clk = ~clk;

  logic core_rst_n = 0, resume_rst_n = 0, rtc_rst_n = 0, pwrbtn_ovr = 0;
  logic [7:0] addr = 8'h02;
  logic wr_en = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic tmr_sts = 0, gbl_sts = 0, pwrbtn_sts = 0, rtc_sts = 0, pcie_wake_sts = 0, sci_mode = 0;
  logic sci, smi, wake;

  pm_event_enable uut (
    .clk(clk), .core_rst_n(core_rst_n), .resume_rst_n(resume_rst_n), .rtc_rst_n(rtc_rst_n),
    .pwrbtn_ovr(pwrbtn_ovr), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .tmr_sts(tmr_sts), .gbl_sts(gbl_sts), .pwrbtn_sts(pwrbtn_sts), .rtc_sts(rtc_sts),
    .pcie_wake_sts(pcie_wake_sts), .sci_mode(sci_mode), .sci(sci), .smi(smi), .wake(wake));

  int vectors = 0, errors = 0;
  string tag = "R1";
  bit m_tmr, m_gbl, m_pb, m_rtc, m_pcie;

  task automatic model_edge();
    bit hit;
    hit = wr_en && addr == 8'h02;
    if (!core_rst_n) begin m_tmr = 0; m_gbl = 0; end
    else if (hit) begin m_tmr = wdata[0]; m_gbl = wdata[5]; end
    if (!resume_rst_n) begin m_pb = 0; m_pcie = 0; end
    else if (hit) begin m_pb = wdata[8]; m_pcie = wdata[14]; end
    if (!rtc_rst_n || pwrbtn_ovr) m_rtc = 0;
    else if (hit) m_rtc = wdata[10];
  endtask

  task automatic compare();
    logic [15:0] er;
    bit st, esci, esmi, ewake;
    er = 0;
    if (addr == 8'h02) begin
      er[0] = m_tmr; er[5] = m_gbl; er[8] = m_pb; er[10] = m_rtc; er[14] = m_pcie;
    end
    st = (m_tmr & tmr_sts) | (m_pb & pwrbtn_sts) | (m_rtc & rtc_sts);
    esci = (st & sci_mode) | (m_gbl & gbl_sts);
    esmi = st & ~sci_mode;
    ewake = (m_rtc & rtc_sts) | pwrbtn_sts | (pcie_wake_sts & ~m_pcie);
    vectors++;
    if (rdata !== er || sci !== esci || smi !== esmi || wake !== ewake) begin
      errors++;
      $display("FAIL %s: rdata=%h sci=%b smi=%b wake=%b expected rdata=%h sci=%b smi=%b wake=%b",
               tag, rdata, sci, smi, wake, er, esci, esmi, ewake);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); model_edge();
      @(negedge clk); compare();
    end
  endtask

  task automatic wr(logic [15:0] d);
    wr_en = 1; addr = 8'h02; wdata = d; cyc(); wr_en = 0;
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    m_tmr = 0; m_gbl = 0; m_pb = 0; m_rtc = 0; m_pcie = 0;
    tag = "R1"; cyc(2);
    @(negedge clk); core_rst_n = 1; resume_rst_n = 1; rtc_rst_n = 1;
    cyc(); addr = 8'h04; cyc(); addr = 8'h02;
    tag = "R2"; wr(16'hFFFF); cyc(); wr(16'h0000);
    wr_en = 1; addr = 8'h06; wdata = 16'hFFFF; cyc(); wr_en = 0; addr = 8'h02; cyc();
    wr(16'hBADA); cyc();
    tag = "R3"; wr(16'h4521); core_rst_n = 0; cyc(2); core_rst_n = 1; cyc();
    tag = "R4"; wr(16'h4521); resume_rst_n = 0; cyc(2); resume_rst_n = 1; cyc();
    tag = "R5"; wr(16'h4521); core_rst_n = 0; resume_rst_n = 0; cyc(2);
    core_rst_n = 1; resume_rst_n = 1; cyc();
    pwrbtn_ovr = 1; wr_en = 1; wdata = 16'h0400; cyc(); pwrbtn_ovr = 0; wr_en = 0; cyc();
    wr(16'h0400); rtc_rst_n = 0; cyc(); rtc_rst_n = 1; cyc();
    tag = "R6"; wr(16'h0001); tmr_sts = 1; sci_mode = 0; cyc(); sci_mode = 1; cyc();
    wr(16'h0000); cyc(); tmr_sts = 0;
    tag = "R7"; wr(16'h0020); gbl_sts = 1; sci_mode = 0; cyc(); sci_mode = 1; cyc(); gbl_sts = 0; cyc();
    tag = "R8"; wr(16'h0000); pwrbtn_sts = 1; cyc(); wr(16'h0100); cyc(); sci_mode = 0; cyc(); pwrbtn_sts = 0; cyc();
    tag = "R9"; wr(16'h0000); rtc_sts = 1; cyc(); wr(16'h0400); cyc(); sci_mode = 1; cyc(); rtc_sts = 0; cyc();
    tag = "R10"; wr(16'h0000); pcie_wake_sts = 1; cyc(); wr(16'h4000); cyc(); pcie_wake_sts = 0; cyc();
    tag = "R11"; wr(16'h0521); tmr_sts = 1; cyc(5); tmr_sts = 0; cyc();
    for (int i = 0; i < 4000; i++) begin
      tag = "R11";
      wr_en = ($urandom_range(0, 3) == 0);
      addr = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255)) : 8'h02;
      wdata = 16'($urandom);
      pwrbtn_ovr = ($urandom_range(0, 39) == 0);
      core_rst_n = ($urandom_range(0, 59) != 0);
      resume_rst_n = ($urandom_range(0, 79) != 0);
      rtc_rst_n = ($urandom_range(0, 119) != 0);
      {tmr_sts, gbl_sts, pwrbtn_sts, rtc_sts, pcie_wake_sts, sci_mode} = 6'($urandom);
      cyc();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule